// File: doc/BRIEF.md
# Dual Timer/Counter Unit

This block provides two 8-bit-register timer/counter channels for a small microcontroller core. Each channel counts either machine cycles, marked by a one-clock strobe from the core, or falling edges seen on its own external pin. A mode register picks, for each channel, one of four counting arrangements: a 13-bit counter with a 5-bit prescaler in the low byte, a full 16-bit counter, an 8-bit counter that reloads from the high byte, and a split arrangement where channel 0 becomes two independent 8-bit counters.

Software reaches the mode register, the control register and the four count bytes through a simple register port: a write strobe with a select and a data byte, and a separate combinational read select. Each channel raises a sticky overflow flag that the interrupt controller takes as a request and clears with a one-cycle acknowledge. Software may also write the flags through the control register.

Top module: `tc_dual_unit`

## Requirements
- R1: After reset every register reads 0x00 and both overflow flags are low.
- R2: Register selects are 0 mode, 1 control, 2 channel-0 low, 3 channel-0 high, 4 channel-1 low, 5 channel-1 high; the mode register holds channel 0 in bits 3:0 and channel 1 in bits 7:4, each nibble with the counting arrangement in bits 1:0 and external-pin counting in bit 2; the control register holds run 0 in bit 4, flag 0 in bit 5, run 1 in bit 6, flag 1 in bit 7, and reads 0 in bits 3:0.
- R3: With its run bit clear a channel keeps its count unchanged.
- R4: In pin-counting mode a channel advances once per high-to-low change of its synchronised pin; a low-to-high change does not advance it.
- R5: Arrangement 0 counts on 13 bits, the 5 low bits of the low byte below the high byte; carrying out of the top raises the channel's flag.
- R6: Arrangement 1 counts on 16 bits, high byte above low byte, and raises the flag when the count wraps from 0xFFFF.
- R7: Arrangement 2 counts in the low byte only; on overflow the low byte takes the high byte's value, the high byte is unchanged, and the flag is raised.
- R8: With channel 0 in arrangement 3, its low byte is an 8-bit counter run by run 0 that raises flag 0, and its high byte counts machine cycles while run 1 is set and raises flag 1 on wrap.
- R9: Channel 1 in arrangement 3 holds both count bytes whatever its run bit, pin and strobe do.
- R10: While channel 0 is in arrangement 3 and channel 1 is not, channel 1 counts regardless of run 1 and its overflow raises no flag.
- R11: A register write to a count byte in the same cycle as an increment stores the written value.
- R12: An overflow flag stays set until its acknowledge input or a control-register write clears it; a new overflow in the same cycle as an acknowledge leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_en | input | 1 | One-clock machine-cycle strobe |
| sfr_we | input | 1 | Register write strobe |
| sfr_wsel | input | 3 | Register select for writes |
| sfr_wdata | input | 8 | Write data |
| sfr_rsel | input | 3 | Register select for reads |
| sfr_rdata | output | 8 | Read data, combinational from sfr_rsel |
| ext_pin | input | 2 | External count pins, bit n for channel n |
| irq_ack | input | 2 | Interrupt acknowledge, bit n clears flag n |
| ovf_flag | output | 2 | Overflow flags, bit n for channel n |

## Verification
A corrupted count byte stays visible at the read port from the next clock onward, and because every arrangement funnels its carry into a flag, a wrong carry chain shows up as a flag raised one event early or late, or as a count that lands on the wrong byte after the wrap. The split arrangement is the most fragile, since a wrong run or flag routing shows as channel 1's flag moving when channel 0's high byte wraps, or channel 1's bytes drifting while it should hold. A lost pin edge shows as a count one short right after the pin returns high, within a handful of cycles of the synchroniser delay.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam int BYTE_W   = 8;
  localparam int PRESC_W  = 5;
  localparam int SEL_W    = 3;
  localparam int N_CH     = 2;

  localparam logic [SEL_W-1:0] SEL_MODE = 3'd0;
  localparam logic [SEL_W-1:0] SEL_CTRL = 3'd1;
  localparam logic [SEL_W-1:0] SEL_C0LO = 3'd2;
  localparam logic [SEL_W-1:0] SEL_C0HI = 3'd3;
  localparam logic [SEL_W-1:0] SEL_C1LO = 3'd4;
  localparam logic [SEL_W-1:0] SEL_C1HI = 3'd5;

  typedef enum logic [1:0] {
    M_13     = 2'd0,
    M_16     = 2'd1,
    M_RELOAD = 2'd2,
    M_SPLIT  = 2'd3
  } tc_mode_e;

  typedef struct packed {
    logic [BYTE_W-1:0] hi;
    logic [BYTE_W-1:0] lo;
    logic              ovf;
  } tc_step_t;

  // One counting event applied to a channel's pair of bytes.
  function automatic tc_step_t tc_step(tc_mode_e m, logic [BYTE_W-1:0] hi,
                                       logic [BYTE_W-1:0] lo);
    tc_step_t r;
    logic [BYTE_W+PRESC_W:0] c13;
    logic [2*BYTE_W:0]       c16;
    logic [BYTE_W:0]         c8;
    r.hi = hi;
    r.lo = lo;
    r.ovf = 1'b0;
    c13 = {1'b0, hi, lo[PRESC_W-1:0]} + 1'b1;
    c16 = {1'b0, hi, lo} + 1'b1;
    c8  = {1'b0, lo} + 1'b1;
    case (m)
      M_13: begin
        r.hi  = c13[BYTE_W+PRESC_W-1:PRESC_W];
        r.lo  = {lo[BYTE_W-1:PRESC_W], c13[PRESC_W-1:0]};
        r.ovf = c13[BYTE_W+PRESC_W];
      end
      M_16: begin
        r.hi  = c16[2*BYTE_W-1:BYTE_W];
        r.lo  = c16[BYTE_W-1:0];
        r.ovf = c16[2*BYTE_W];
      end
      M_RELOAD: begin
        r.lo  = c8[BYTE_W] ? hi : c8[BYTE_W-1:0];
        r.ovf = c8[BYTE_W];
      end
      default: begin
        r.lo  = c8[BYTE_W-1:0];
        r.ovf = c8[BYTE_W];
      end
    endcase
    return r;
  endfunction

  // Plain byte increment with carry out, used by the split high byte.
  function automatic logic [BYTE_W:0] tc_inc8(logic [BYTE_W-1:0] v);
    return {1'b0, v} + 1'b1;
  endfunction
endpackage

// File: rtl/tc_edge.sv
module tc_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_en,
  input  logic pin,
  output logic fall
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   samp_q;
  logic                   pin_s;

  assign pin_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      samp_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
      if (cyc_en) samp_q <= pin_s;
    end
  end

  assign fall = cyc_en && samp_q && !pin_s;

  // R4: one counted edge cannot be followed by another on the next clock
  p_edge_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/tc_chan.sv
module tc_chan
  import tc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  tc_mode_e          mode,
  input  logic              tick,
  input  logic              hi_tick,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] lo,
  output logic [BYTE_W-1:0] hi,
  output logic              ovf_main,
  output logic              ovf_hi
);
  tc_step_t        nxt;
  logic [BYTE_W:0] hi_inc;
  logic            split;

  assign nxt    = tc_step(mode, hi, lo);
  assign hi_inc = tc_inc8(hi);
  assign split  = (mode == M_SPLIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo <= '0;
      hi <= '0;
    end else begin
      if (wr_lo)     lo <= wdata;
      else if (tick) lo <= nxt.lo;
      if (wr_hi)                  hi <= wdata;
      else if (split && hi_tick)  hi <= hi_inc[BYTE_W-1:0];
      else if (!split && tick)    hi <= nxt.hi;
    end
  end

  assign ovf_main = tick && nxt.ovf && !wr_lo && !(wr_hi && !split);
  assign ovf_hi   = split && hi_tick && hi_inc[BYTE_W] && !wr_hi;

  // R3: no event and no write leaves both bytes untouched
  p_freeze_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !hi_tick && !wr_lo && !wr_hi) |=> ($stable(lo) && $stable(hi)));

  // R7: the reload byte changes only through a write
  p_reload_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_RELOAD && !wr_hi) |=> $stable(hi));

  // R11: a written low byte wins over a same-cycle increment
  p_write_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (lo == $past(wdata)));
endmodule

// File: rtl/tc_dual_unit.sv
module tc_dual_unit
  import tc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_en,
  input  logic              sfr_we,
  input  logic [SEL_W-1:0]  sfr_wsel,
  input  logic [BYTE_W-1:0] sfr_wdata,
  input  logic [SEL_W-1:0]  sfr_rsel,
  output logic [BYTE_W-1:0] sfr_rdata,
  input  logic [N_CH-1:0]   ext_pin,
  input  logic [N_CH-1:0]   irq_ack,
  output logic [N_CH-1:0]   ovf_flag
);
  localparam int NIB = BYTE_W / 2;

  logic [BYTE_W-1:0] mode_q;
  logic [N_CH-1:0]   run_q, flag_q;
  logic [N_CH-1:0]   fall, ev, pin_cnt, tick, hi_tick, ovf_main, ovf_hi, set_flag;
  logic [N_CH-1:0]   wr_lo, wr_hi;
  logic [BYTE_W-1:0] lo [N_CH];
  logic [BYTE_W-1:0] hi [N_CH];
  tc_mode_e          mode [N_CH];
  logic              we_mode, we_ctrl, split0, hold1;

  assign we_mode = sfr_we && (sfr_wsel == SEL_MODE);
  assign we_ctrl = sfr_we && (sfr_wsel == SEL_CTRL);
  assign wr_lo   = {sfr_we && sfr_wsel == SEL_C1LO, sfr_we && sfr_wsel == SEL_C0LO};
  assign wr_hi   = {sfr_we && sfr_wsel == SEL_C1HI, sfr_we && sfr_wsel == SEL_C0HI};

  assign split0 = (mode[0] == M_SPLIT);
  assign hold1  = (mode[1] == M_SPLIT);

  assign tick[0]    = run_q[0] && ev[0];
  assign hi_tick[0] = split0 && run_q[1] && cyc_en;
  assign tick[1]    = !hold1 && ev[1] && (split0 || run_q[1]);
  assign hi_tick[1] = 1'b0;

  assign set_flag[0] = ovf_main[0];
  assign set_flag[1] = split0 ? ovf_hi[0] : ovf_main[1];

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    assign mode[g]    = tc_mode_e'(mode_q[g*NIB +: 2]);
    assign pin_cnt[g] = mode_q[g*NIB + 2];
    assign ev[g]      = cyc_en && (pin_cnt[g] ? fall[g] : 1'b1);

    tc_edge #(.SYNC_STAGES(2)) u_edge (
      .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .pin(ext_pin[g]), .fall(fall[g])
    );

    tc_chan u_chan (
      .clk(clk), .rst_n(rst_n), .mode(mode[g]), .tick(tick[g]),
      .hi_tick(hi_tick[g]), .wr_lo(wr_lo[g]), .wr_hi(wr_hi[g]),
      .wdata(sfr_wdata), .lo(lo[g]), .hi(hi[g]),
      .ovf_main(ovf_main[g]), .ovf_hi(ovf_hi[g])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           flag_q[g] <= 1'b0;
      else if (set_flag[g]) flag_q[g] <= 1'b1;
      else if (irq_ack[g])  flag_q[g] <= 1'b0;
      else if (we_ctrl)     flag_q[g] <= sfr_wdata[NIB + 2*g + 1];
    end

    // R12: a set flag is kept until acknowledge or a control write
    p_flag_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[g] && !irq_ack[g] && !we_ctrl) |=> flag_q[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      run_q  <= '0;
    end else begin
      if (we_mode) mode_q <= sfr_wdata;
      if (we_ctrl) run_q  <= {sfr_wdata[NIB+2], sfr_wdata[NIB]};
    end
  end

  always_comb begin
    case (sfr_rsel)
      SEL_MODE: sfr_rdata = mode_q;
      SEL_CTRL: sfr_rdata = {flag_q[1], run_q[1], flag_q[0], run_q[0], {NIB{1'b0}}};
      SEL_C0LO: sfr_rdata = lo[0];
      SEL_C0HI: sfr_rdata = hi[0];
      SEL_C1LO: sfr_rdata = lo[1];
      SEL_C1HI: sfr_rdata = hi[1];
      default:  sfr_rdata = '0;
    endcase
  end

  assign ovf_flag = flag_q;

  // R9: channel 1 in the split arrangement holds unless written
  p_ch1_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hold1 && !wr_lo[1] && !wr_hi[1]) |=> ($stable(lo[1]) && $stable(hi[1])));

  // R10: channel 1 wrapping while channel 0 is split leaves flag 1 alone
  p_split_noflag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (split0 && ovf_main[1] && !ovf_hi[0] && !flag_q[1] && !we_ctrl) |=> !flag_q[1]);
endmodule

// File: tb/tb_tc_dual_unit.sv
`timescale 1ns/1ps
module tb_tc_dual_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_en = 1'b0;
  logic       sfr_we = 1'b0;
  logic [2:0] sfr_wsel = '0;
  logic [7:0] sfr_wdata = '0;
  logic [2:0] sfr_rsel = '0;
  logic [7:0] sfr_rdata;
  logic [1:0] ext_pin = 2'b11;
  logic [1:0] irq_ack = 2'b00;
  logic [1:0] ovf_flag;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  localparam logic [2:0] MD = 3'd0, CT = 3'd1, L0 = 3'd2, H0 = 3'd3, L1 = 3'd4, H1 = 3'd5;

  always #4 clk = ~clk;

  tc_dual_unit dut (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .sfr_we(sfr_we),
    .sfr_wsel(sfr_wsel), .sfr_wdata(sfr_wdata), .sfr_rsel(sfr_rsel),
    .sfr_rdata(sfr_rdata), .ext_pin(ext_pin), .irq_ack(irq_ack), .ovf_flag(ovf_flag)
  );

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] sel, logic [7:0] d);
    @(negedge clk); sfr_we = 1'b1; sfr_wsel = sel; sfr_wdata = d;
    @(negedge clk); sfr_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] sel, output logic [7:0] v);
    sfr_rsel = sel; #1; v = sfr_rdata;
  endtask

  task automatic chk_reg(string tag, logic [2:0] sel, logic [7:0] exp);
    logic [7:0] v;
    rd(sel, v);
    check(tag, v, exp);
  endtask

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cyc_en = 1'b1;
      @(negedge clk); cyc_en = 1'b0;
    end
  endtask

  task automatic pin_lo(int ch);
    @(negedge clk); ext_pin[ch] = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic pin_hi(int ch);
    @(negedge clk); ext_pin[ch] = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic pulses(int ch, int n);
    for (int i = 0; i < n; i++) begin pin_lo(ch); pin_hi(ch); end
  endtask

  task automatic pin_mode_on();
    cyc_en = 1'b1; ext_pin = 2'b11;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk_reg("R1 mode", MD, 8'h00);
    chk_reg("R1 ctrl", CT, 8'h00);
    chk_reg("R1 c0lo", L0, 8'h00);
    chk_reg("R1 c0hi", H0, 8'h00);
    chk_reg("R1 c1lo", L1, 8'h00);
    chk_reg("R1 c1hi", H1, 8'h00);
    check("R1 flags", ovf_flag, 0);
  endtask

  task automatic t_regs();
    wr(MD, 8'hA9); chk_reg("R2 mode readback", MD, 8'hA9);
    wr(CT, 8'hFF); chk_reg("R2 ctrl low nibble reads zero", CT, 8'hF0);
    check("R2 flags follow ctrl bits 5,7", ovf_flag, 3);
    wr(CT, 8'h00);
    wr(L0, 8'h12); wr(H0, 8'h34); wr(L1, 8'h56); wr(H1, 8'h78);
    chk_reg("R2 c0lo", L0, 8'h12); chk_reg("R2 c0hi", H0, 8'h34);
    chk_reg("R2 c1lo", L1, 8'h56); chk_reg("R2 c1hi", H1, 8'h78);
    wr(MD, 8'h00);
  endtask

  task automatic t_mode0();
    wr(MD, 8'h04); wr(H0, 8'h00); wr(L0, 8'h1C);
    pin_mode_on();
    wr(CT, 8'h10);
    pin_lo(0); chk_reg("R4 falling edge counts", L0, 8'h1D);
    pin_hi(0); chk_reg("R4 rising edge ignored", L0, 8'h1D);
    pulses(0, 3);
    chk_reg("R5 13-bit carry hi", H0, 8'h01);
    chk_reg("R5 13-bit carry lo", L0, 8'h00);
    wr(CT, 8'h00); wr(H0, 8'hFF); wr(L0, 8'h1C); wr(CT, 8'h10);
    pulses(0, 5);
    chk_reg("R5 wrap hi", H0, 8'h00);
    chk_reg("R5 wrap lo", L0, 8'h01);
    check("R5 flag0 raised", ovf_flag, 1);
    wr(CT, 8'h20);
    pulses(0, 3);
    chk_reg("R3 stopped lo", L0, 8'h01);
    chk_reg("R3 stopped hi", H0, 8'h00);
    chk_reg("R3 ctrl keeps flag", CT, 8'h20);
  endtask

  task automatic t_mode1();
    wr(MD, 8'h05); wr(CT, 8'h00); wr(H0, 8'h00); wr(L0, 8'hFC); wr(CT, 8'h10);
    pulses(0, 5);
    chk_reg("R6 hi", H0, 8'h01); chk_reg("R6 lo", L0, 8'h01);
    check("R6 no flag", ovf_flag, 0);
    wr(CT, 8'h00); wr(H0, 8'hFF); wr(L0, 8'hFC); wr(CT, 8'h10);
    pulses(0, 6);
    chk_reg("R6 wrap hi", H0, 8'h00); chk_reg("R6 wrap lo", L0, 8'h02);
    check("R6 flag0", ovf_flag, 1);
  endtask

  task automatic t_mode2();
    wr(MD, 8'h06); wr(CT, 8'h00); wr(L0, 8'hFC); wr(H0, 8'h50); wr(CT, 8'h10);
    pulses(0, 5);
    chk_reg("R7 reloaded lo", L0, 8'h51);
    chk_reg("R7 hi unchanged", H0, 8'h50);
    check("R7 flag0", ovf_flag, 1);
  endtask

  task automatic t_mode3();
    wr(MD, 8'h07); wr(CT, 8'h00); wr(L0, 8'hFC); wr(H0, 8'h00); wr(CT, 8'h10);
    pulses(0, 6);
    chk_reg("R8 low byte", L0, 8'h02);
    chk_reg("R8 high byte idle without run1", H0, 8'h00);
    check("R8 flag0 only", ovf_flag, 1);
    cyc_en = 1'b0;
    wr(CT, 8'h00); wr(L1, 8'h00); wr(H1, 8'h00); wr(H0, 8'hFC);
    wr(CT, 8'h40);
    cycles(6);
    chk_reg("R8 high byte timer", H0, 8'h02);
    chk_reg("R8 low byte held", L0, 8'h02);
    check("R8 flag1 from high byte", ovf_flag, 2);
    chk_reg("R10 ch1 counts while split", L1, 8'h06);
    wr(MD, 8'h17); wr(CT, 8'h00); wr(H1, 8'hFF); wr(L1, 8'hFE);
    cycles(3);
    chk_reg("R10 ch1 wrap hi", H1, 8'h00);
    chk_reg("R10 ch1 wrap lo", L1, 8'h01);
    check("R10 no flag from ch1", ovf_flag, 0);
  endtask

  task automatic t_ch1_hold();
    wr(MD, 8'h70); wr(CT, 8'h00); wr(L1, 8'h11); wr(H1, 8'h22); wr(CT, 8'h40);
    pin_mode_on();
    pulses(1, 3);
    chk_reg("R9 ch1 lo held", L1, 8'h11);
    chk_reg("R9 ch1 hi held", H1, 8'h22);
    check("R9 no flag", ovf_flag, 0);
    cyc_en = 1'b0;
  endtask

  task automatic t_write_prio();
    logic [7:0] v;
    wr(MD, 8'h01); wr(CT, 8'h00); wr(H0, 8'h00); wr(L0, 8'h00); wr(CT, 8'h10);
    cyc_en = 1'b1;
    sfr_rsel = L0;
    @(negedge clk); sfr_we = 1'b1; sfr_wsel = L0; sfr_wdata = 8'h80;
    @(posedge clk); #1; v = sfr_rdata;
    check("R11 write beats increment", v, 8'h80);
    @(negedge clk); sfr_we = 1'b0;
    @(posedge clk); #1; v = sfr_rdata;
    check("R11 counting resumes", v, 8'h81);
    @(negedge clk); cyc_en = 1'b0;
    wr(CT, 8'h00);
  endtask

  task automatic t_flags();
    wr(MD, 8'h02); wr(CT, 8'h10); wr(H0, 8'h00); wr(L0, 8'hFF);
    cycles(1);
    check("R12 flag set on reload", ovf_flag, 1);
    chk_reg("R7 timer reload value", L0, 8'h00);
    cycles(1);
    check("R12 flag sticky", ovf_flag, 1);
    @(negedge clk); irq_ack = 2'b01;
    @(negedge clk); irq_ack = 2'b00;
    check("R12 ack clears", ovf_flag, 0);
    wr(L0, 8'hFF); cycles(1);
    check("R12 set again", ovf_flag, 1);
    wr(CT, 8'h10);
    check("R12 ctrl write clears", ovf_flag, 0);
    wr(L0, 8'hFF);
    @(negedge clk); cyc_en = 1'b1; irq_ack = 2'b01;
    @(negedge clk); cyc_en = 1'b0; irq_ack = 2'b00;
    check("R12 set wins over ack", ovf_flag, 1);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_mode0();
    t_mode1();
    t_mode2();
    t_mode3();
    t_ch1_hold();
    t_write_prio();
    t_flags();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule